// File: doc/BRIEF.md
# DRAM Refresh and Start-up Sequencer

This block keeps an asynchronous, address-multiplexed DRAM with a 16-bit data bus alive. After reset it keeps every strobe inactive for a long power-up pause. It then runs a fixed burst of warm-up refresh cycles on its own. After that it owes the memory one refresh per rate interval and settles each one through a request/grant handshake with the access controller, so that a refresh never lands inside a read or write.

Every refresh is a CAS-before-RAS cycle. The memory supplies the row from its own counter, so the block drives no address and touches neither WE, OE nor data. The block drives RAS and both byte CAS strobes only while it owns the bus, and it reports ownership so that the access controller can release its own strobe drivers. Refreshes that cannot be served at once are stored as a bounded debt. All timing limits are parameters in clock cycles.

Top module: `dram_refresh_seq`

## Requirements
- R1: While rst_ni is low, ras_n_o, lcas_n_o and ucas_n_o are high, and ready_o, ref_req_o and own_bus_o are low.
- R2: The strobes stay high during the first PAUSE_CYC rising clock edges after reset release. The first warm-up cycle drives both CAS strobes low on edge PAUSE_CYC+1.
- R3: After the pause, exactly WARM_CNT refresh cycles run without any request or grant. ready_o then rises at the end of the last one and never falls again until reset.
- R4: In every refresh cycle, lcas_n_o and ucas_n_o are equal at all times. They fall exactly CSR_CYC cycles before ras_n_o falls, and they rise exactly CHR_CYC cycles after it, while ras_n_o is still low.
- R5: ras_n_o stays low for exactly RAS_CYC cycles. Between cycles it stays high for at least RP_CYC cycles. Successive RAS falls are at least RC_CYC cycles apart, and each RAS fall comes at least RPC_CYC cycles after the previous CAS rise.
- R6: Once ready, one refresh is owed every INTERVAL_CYC cycles. With prompt grants, any window of 512*INTERVAL_CYC cycles contains exactly 512 RAS falls.
- R7: ref_req_o is high only when ready, when at least one refresh is owed and when no cycle is in progress. A cycle starts on the edge where ref_req_o and ref_gnt_i are both high, and never without a grant once ready.
- R8: The count of owed refreshes saturates at MAX_OWED. After a long stall, the catch-up burst has at least MAX_OWED cycles and at most MAX_OWED plus the intervals elapsed during the burst plus one.
- R9: own_bus_o is high for exactly CSR_CYC+RAS_CYC+PRE_CYC cycles per refresh, from the CAS fall onward. Here PRE_CYC is the largest of RP_CYC, RPC_CYC and RC_CYC-RAS_CYC. No strobe is ever low while own_bus_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ref_gnt_i | input | 1 | Access controller grants the bus for one refresh |
| ref_req_o | output | 1 | A refresh is owed and the sequencer is idle |
| own_bus_o | output | 1 | The sequencer drives the strobes |
| ras_n_o | output | 1 | Row strobe, active low |
| lcas_n_o | output | 1 | Lower-byte column strobe, active low |
| ucas_n_o | output | 1 | Upper-byte column strobe, active low |
| ready_o | output | 1 | Start-up finished; normal access allowed |

## Verification
The sequencer is tried with three grant patterns, and each one separates a different class of faults. The warm-up runs with no grant at all, which exposes wrong pause lengths and wrong warm-up counts. Prompt one-cycle grants over a window of 512 intervals show whether the refresh rate is exact. A grant withheld for about a hundred intervals and then released shows whether the debt saturates or keeps growing, and whether any refresh starts without a grant. In every cycle, the strobe edge spacings are compared against expectations that the grant driver queues.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;
  typedef enum logic [1:0] {PH_PAUSE, PH_WARM, PH_RUN} phase_e;
  typedef enum logic [2:0] {CB_IDLE, CB_SETUP, CB_HOLD, CB_RASLO, CB_PRE} cbr_state_e;
endpackage

// File: rtl/dram_ref_tick.sv
module dram_ref_tick #(
  parameter int PERIOD = 1560
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int W = $clog2(PERIOD + 1);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= W'(PERIOD - 1);
    else if (!en_i || cnt_q == '0)  cnt_q <= W'(PERIOD - 1);
    else                            cnt_q <= cnt_q - 1'b1;
  end

  assign tick_o = en_i && (cnt_q == '0);
endmodule

// File: rtl/dram_ref_debt.sv
module dram_ref_debt #(
  parameter int MAX_OWED = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic inc_i,
  input  logic dec_i,
  output logic pending_o
);
  localparam int W = $clog2(MAX_OWED + 1);
  logic [W-1:0] owed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) owed_q <= '0;
    else begin
      unique case ({inc_i, dec_i})
        2'b10:   if (owed_q != W'(MAX_OWED)) owed_q <= owed_q + 1'b1;
        2'b01:   if (owed_q != '0)           owed_q <= owed_q - 1'b1;
        default: owed_q <= owed_q;
      endcase
    end
  end

  assign pending_o = (owed_q != '0);

  assert_owed_cap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    owed_q <= W'(MAX_OWED));
  assert_owed_sat_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !dec_i && owed_q == W'(MAX_OWED)) |=> owed_q == W'(MAX_OWED));
endmodule

// File: rtl/dram_ref_cbr.sv
module dram_ref_cbr
  import dram_ref_pkg::*;
#(
  parameter int CSR_CYC = 1,
  parameter int CHR_CYC = 1,
  parameter int RAS_CYC = 3,
  parameter int PRE_CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic ras_n_o,
  output logic cas_n_o,
  output logic busy_o,
  output logic done_o
);
  localparam int M0 = (CSR_CYC > CHR_CYC) ? CSR_CYC : CHR_CYC;
  localparam int M1 = (RAS_CYC > PRE_CYC) ? RAS_CYC : PRE_CYC;
  localparam int MX = (M0 > M1) ? M0 : M1;
  localparam int CW = $clog2(MX + 1);

  cbr_state_e    st_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= CB_IDLE;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        CB_IDLE: if (start_i) begin
          st_q  <= CB_SETUP;
          cnt_q <= CW'(CSR_CYC - 1);
        end
        CB_SETUP: if (cnt_q == '0) begin
          st_q  <= CB_HOLD;
          cnt_q <= CW'(CHR_CYC - 1);
        end else cnt_q <= cnt_q - 1'b1;
        CB_HOLD: if (cnt_q == '0) begin
          st_q  <= CB_RASLO;
          cnt_q <= CW'(RAS_CYC - CHR_CYC - 1);
        end else cnt_q <= cnt_q - 1'b1;
        CB_RASLO: if (cnt_q == '0) begin
          st_q  <= CB_PRE;
          cnt_q <= CW'(PRE_CYC - 1);
        end else cnt_q <= cnt_q - 1'b1;
        CB_PRE: if (cnt_q == '0) st_q <= CB_IDLE;
                else cnt_q <= cnt_q - 1'b1;
        default: st_q <= CB_IDLE;
      endcase
    end
  end

  assign ras_n_o = !(st_q == CB_HOLD || st_q == CB_RASLO);
  assign cas_n_o = !(st_q == CB_SETUP || st_q == CB_HOLD);
  assign busy_o  = (st_q != CB_IDLE);
  assign done_o  = (st_q == CB_PRE) && (cnt_q == '0);

  assert_cas_before_ras_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_n_o) |-> $past(!cas_n_o));
  assert_cas_rise_in_ras_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cas_n_o) |-> !ras_n_o);
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
  import dram_ref_pkg::*;
#(
  parameter int PAUSE_CYC    = 20000,
  parameter int WARM_CNT     = 8,
  parameter int INTERVAL_CYC = 1560,
  parameter int CSR_CYC      = 1,
  parameter int CHR_CYC      = 1,
  parameter int RAS_CYC      = 3,
  parameter int RP_CYC       = 2,
  parameter int RPC_CYC      = 1,
  parameter int RC_CYC       = 5,
  parameter int MAX_OWED     = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_gnt_i,
  output logic ref_req_o,
  output logic own_bus_o,
  output logic ras_n_o,
  output logic lcas_n_o,
  output logic ucas_n_o,
  output logic ready_o
);
  localparam int PRE_A   = (RP_CYC > RPC_CYC) ? RP_CYC : RPC_CYC;
  localparam int PRE_CYC = ((RC_CYC - RAS_CYC) > PRE_A) ? (RC_CYC - RAS_CYC) : PRE_A;
  localparam int PW      = $clog2(PAUSE_CYC + 1);
  localparam int WW      = $clog2(WARM_CNT + 1);

  phase_e        phase_q;
  logic [PW-1:0] pause_q;
  logic [WW-1:0] warm_q;
  logic          busy, done, cas_n, tick, pending, warm_start, run_start;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_PAUSE;
      pause_q <= PW'(PAUSE_CYC - 1);
      warm_q  <= '0;
    end else begin
      unique case (phase_q)
        PH_PAUSE: if (pause_q == '0) phase_q <= PH_WARM;
                  else pause_q <= pause_q - 1'b1;
        PH_WARM: if (done) begin
          if (warm_q == WW'(WARM_CNT - 1)) phase_q <= PH_RUN;
          else warm_q <= warm_q + 1'b1;
        end
        default: phase_q <= phase_q;
      endcase
    end
  end

  assign warm_start = (phase_q == PH_WARM) && !busy;
  assign ref_req_o  = (phase_q == PH_RUN) && pending && !busy;
  assign run_start  = ref_req_o && ref_gnt_i;
  assign ready_o    = (phase_q == PH_RUN);
  assign own_bus_o  = busy;
  assign lcas_n_o   = cas_n;
  assign ucas_n_o   = cas_n;

  dram_ref_tick #(.PERIOD(INTERVAL_CYC)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(ready_o), .tick_o(tick));

  dram_ref_debt #(.MAX_OWED(MAX_OWED)) u_debt (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(tick), .dec_i(run_start),
    .pending_o(pending));

  dram_ref_cbr #(.CSR_CYC(CSR_CYC), .CHR_CYC(CHR_CYC), .RAS_CYC(RAS_CYC),
                 .PRE_CYC(PRE_CYC)) u_cbr (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(warm_start || run_start),
    .ras_n_o(ras_n_o), .cas_n_o(cas_n), .busy_o(busy), .done_o(done));

  assert_pause_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_PAUSE) |-> (ras_n_o && lcas_n_o && ucas_n_o));
  assert_ready_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> ready_o);
  assert_req_when_ready_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_req_o |-> (ready_o && !own_bus_o));
  assert_own_covers_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ras_n_o || !lcas_n_o) |-> own_bus_o);
endmodule

// File: tb/dram_refresh_seq_tb_top.sv
module dram_refresh_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PAUSE = 50, WARM = 8, INTV = 20, CSR = 2, CHR = 2, RAS = 5;
  localparam int RP = 3, RPC = 2, RC = 9, MAXO = 8;
  localparam int PRE = 4;  // largest of RP, RPC, RC-RAS
  localparam int STALL = 2000;

  logic clk = 1'b0, rst_n = 1'b0, gnt = 1'b0;
  logic req, own, ras_n, lcas_n, ucas_n, ready;

  dram_refresh_seq #(.PAUSE_CYC(PAUSE), .WARM_CNT(WARM), .INTERVAL_CYC(INTV),
    .CSR_CYC(CSR), .CHR_CYC(CHR), .RAS_CYC(RAS), .RP_CYC(RP), .RPC_CYC(RPC),
    .RC_CYC(RC), .MAX_OWED(MAXO)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ref_gnt_i(gnt), .ref_req_o(req),
    .own_bus_o(own), .ras_n_o(ras_n), .lcas_n_o(lcas_n), .ucas_n_o(ucas_n),
    .ready_o(ready));

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {int csr; int chr; int ras;} exp_t;
  exp_t exp_q[$];
  int n_checks = 0, n_fail = 0, n_grants = 0;
  bit gnt_en = 1'b0, done_flag = 1'b0;

  task automatic check(bit ok, string tag, int act, int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic push_exp(int n);
    for (int i = 0; i < n; i++) exp_q.push_back('{CSR, CHR, RAS});
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  // monitor
  int cyc = 0, t_cas_fall = 0, t_ras_fall = -1000, t_cas_rise = -1000;
  int t_ras_rise = -1000, t_own_rise = 0, first_cas = -1, last_setup = 0, last_hold = 0;
  int n_falls = 0, n_pulses = 0, v_pair = 0, v_own = 0, v_req = 0, v_rdy = 0;
  bit p_ras = 1'b1, p_cas = 1'b1, p_own = 1'b0, rdy_seen = 1'b0;

  initial forever begin
    @(negedge clk);
    if (rst_n) begin
      cyc++;
      if (lcas_n !== ucas_n) v_pair++;
      if ((!ras_n || !lcas_n) && !own) v_own++;
      if (req && (own || !ready)) v_req++;
      if (rdy_seen && !ready) v_rdy++;
      if (ready) rdy_seen = 1'b1;
      if (!p_own && own) t_own_rise = cyc;
      if (p_own && !own) check(cyc - t_own_rise == CSR + RAS + PRE, "R9 own_bus length",
                               cyc - t_own_rise, CSR + RAS + PRE);
      if (p_cas && !lcas_n) begin
        t_cas_fall = cyc;
        if (first_cas < 0) first_cas = cyc;
      end
      if (p_ras && !ras_n) begin
        last_setup = cyc - t_cas_fall;
        check(!lcas_n, "R4 cas low at ras fall", lcas_n, 0);
        if (n_falls > 0) begin
          check(cyc - t_ras_rise >= RP, "R5 ras precharge", cyc - t_ras_rise, RP);
          check(cyc - t_ras_fall >= RC, "R5 ras period", cyc - t_ras_fall, RC);
          check(cyc - t_cas_rise >= RPC, "R5 cas precharge", cyc - t_cas_rise, RPC);
        end
        t_ras_fall = cyc;
        n_falls++;
      end
      if (!p_cas && lcas_n) begin
        last_hold = cyc - t_ras_fall;
        t_cas_rise = cyc;
        check(!ras_n, "R4 cas rises under ras low", ras_n, 0);
      end
      if (!p_ras && ras_n) begin
        t_ras_rise = cyc;
        n_pulses++;
        if (exp_q.size() == 0) check(1'b0, "R7 cycle without expectation", 1, 0);
        else begin
          exp_t e;
          e = exp_q.pop_front();
          check(last_setup == e.csr, "R4 cas setup", last_setup, e.csr);
          check(last_hold == e.chr, "R4 cas hold", last_hold, e.chr);
          check(cyc - t_ras_fall == e.ras, "R5 ras low width", cyc - t_ras_fall, e.ras);
        end
      end
      p_ras = ras_n; p_cas = lcas_n; p_own = own;
    end
  end

  // access controller model / driver
  initial forever begin
    @(negedge clk);
    if (gnt_en && req) begin
      gnt = 1'b1;
      n_grants++;
      push_exp(1);
    end else gnt = 1'b0;
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      summary();
      $finish;
    end
  end

  initial begin
    int f0, t0, len, dur;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(ras_n && lcas_n && ucas_n, "R1 strobes high in reset", {ras_n, lcas_n, ucas_n}, 7);
    check(!ready && !req && !own, "R1 outputs low in reset", {ready, req, own}, 0);
    push_exp(WARM);
    rst_n = 1'b1;
    while (!ready) @(negedge clk);
    check(first_cas == PAUSE + 1, "R2 first cas edge", first_cas, PAUSE + 1);
    check(n_pulses == WARM, "R3 warm-up cycle count", n_pulses, WARM);
    check(exp_q.size() == 0, "R3 warm-up queue drained", exp_q.size(), 0);
    // rate window with prompt grants
    gnt_en = 1'b1;
    repeat (3 * INTV) @(negedge clk);
    f0 = n_falls;
    repeat (512 * INTV) @(negedge clk);
    check(n_falls - f0 == 512, "R6 refreshes per window", n_falls - f0, 512);
    // stall: no grant
    gnt_en = 1'b0;
    repeat (2 * INTV) @(negedge clk);
    f0 = n_falls;
    repeat (STALL) @(negedge clk);
    check(n_falls == f0, "R7 no cycle without grant", n_falls - f0, 0);
    check(req == 1'b1, "R7 request held while owed", req, 1);
    // catch-up burst
    gnt_en = 1'b1;
    f0 = n_falls;
    t0 = cyc;
    do @(negedge clk); while (req || own || gnt);
    len = n_falls - f0;
    dur = cyc - t0;
    check(len >= MAXO, "R8 burst at least cap", len, MAXO);
    check(len <= MAXO + dur / INTV + 1, "R8 burst bounded by cap", len, MAXO + dur / INTV + 1);
    gnt_en = 1'b0;
    repeat (5) @(negedge clk);
    check(exp_q.size() == 0, "R7 each grant gave one cycle", exp_q.size(), 0);
    check(v_pair == 0, "R4 byte strobes equal", v_pair, 0);
    check(v_own == 0, "R9 strobe low without own_bus", v_own, 0);
    check(v_req == 0, "R7 request while busy or not ready", v_req, 0);
    check(v_rdy == 0, "R3 ready fell", v_rdy, 0);
    done_flag = 1'b1;
    summary();
    $finish;
  end
endmodule